// File: doc/BRIEF.md
# Mode-Controlled Control Memory Sequencer

This block owns the connection control memory of a switching controller. Every location holds a data field and a code field. A host presents a command with an operation, a field select, an address and a data value. The block then performs the access in the manner set by a 2-bit operating-mode register. The four modes are:

- a bulk fill that clears every location,
- a fast initialization mode that touches one location per command,
- a normal mode in which single accesses are stretched so the memory can be shared with serial frame traffic,
- a test mode that applies one write to every location and ignores the address.

All timing is counted on a clock that runs at twice the reference rate, so one tick is half a reference cycle. A busy output covers each operation for its exact length. An interface-enable output tells the serial frame and PCM interfaces when they may run. After every hardware reset the mode register selects the bulk fill, so the first command a host issues clears the memory. A typical first command writes the "unassigned channel" data value.

Top module: `cms_seq`

## Requirements
- R1: After reset, mode_out is 2'b00, busy is 0, err is 0 and ifc_en is 0.
- R2: A mode write while idle takes effect on the next edge. The mode encodings are 2'b00 bulk fill, 2'b10 initialization, 2'b11 normal and 2'b01 test. ifc_en is 1 exactly in normal and test mode.
- R3: In bulk-fill mode, any command writes cmd_data into the data field and 4'b0000 into the code field of every location. busy stays high for 512 ticks (256 reference cycles).
- R4: In initialization mode, a read or write touches only the location at cmd_addr. busy stays high for 5 ticks.
- R5: In normal mode, a read or write touches only the location at cmd_addr. busy stays high for 19 ticks.
- R6: cmd_op 2'b10 is a tristate-field sweep. In any mode other than bulk fill, it holds busy for 2070 ticks and leaves the memory unchanged.
- R7: In test mode, cmd_addr is ignored. A write stores cmd_data into the selected field of every location. A read returns location 0. Each test-mode operation holds busy for 4114 ticks.
- R8: cmd_op encodings are 2'b00 read, 2'b01 write, 2'b10 sweep and 2'b11 read. cmd_field 0 selects the data field and 1 selects the code field. A code write uses the low 4 bits of cmd_data. A read places {code, data} on host_rdata, with code in bits [11:8], by the cycle after busy falls.
- R9: A command presented while busy is ignored and sets err. err stays set until reset.
- R10: A mode write made while busy does not change mode_out until the running operation ends. It then takes effect on the edge where busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the reference rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_in | input | 2 | New mode value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code |
| cmd_field | input | 1 | Field select: 0 data, 1 code |
| cmd_addr | input | ADDR_W | Location address |
| cmd_data | input | DATA_W | Write value |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Sticky flag for a command rejected while busy |
| ifc_en | output | 1 | Serial interfaces allowed to run |
| mode_out | output | 2 | Current mode register |
| host_rdata | output | DATA_W+CODE_W | Read result {code, data} |

## Verification
The bench builds the block with DEPTH=16 and keeps the default tick counts. The small depth lets it read back every location after each broadcast fill without a long run. The full-length timings still let it measure each busy window to the exact tick. With a short address, both the top and the bottom location can be probed after the test-mode and bulk-fill passes. A rejected command and a deferred mode write can be placed inside the long sweep and test windows.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [1:0] {
    MODE_FILL = 2'b00,
    MODE_TEST = 2'b01,
    MODE_INIT = 2'b10,
    MODE_NORM = 2'b11
  } cms_mode_e;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_SWEEP = 2'b10;

  function automatic logic ifc_on(input logic [1:0] m);
    return (m == MODE_NORM) || (m == MODE_TEST);
  endfunction

  function automatic logic op_is_read(input logic [1:0] op);
    return (op == OP_READ) || (op == 2'b11);
  endfunction

  function automatic int unsigned op_ticks(input logic [1:0] m, input logic [1:0] op,
                                           input int unsigned fill_t, input int unsigned init_t,
                                           input int unsigned norm_t, input int unsigned sweep_t,
                                           input int unsigned test_t);
    if (m == MODE_FILL) return fill_t;
    if (op == OP_SWEEP) return sweep_t;
    if (m == MODE_TEST) return test_t;
    if (m == MODE_INIT) return init_t;
    return norm_t;
  endfunction
endpackage

// File: rtl/cms_mode_reg.sv
module cms_mode_reg
  import cms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wr_val,
  input  logic       busy,
  input  logic       done,
  output logic [1:0] mode
);
  logic [1:0] pend;
  logic       pend_v;
  logic       hold;

  assign hold = busy && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_FILL;
      pend   <= MODE_FILL;
      pend_v <= 1'b0;
    end else if (wr && hold) begin
      pend   <= wr_val;
      pend_v <= 1'b1;
    end else if (wr) begin
      mode   <= wr_val;
      pend_v <= 1'b0;
    end else if (done && pend_v) begin
      mode   <= pend;
      pend_v <= 1'b0;
    end
  end
endmodule

// File: rtl/cms_timer.sv
module cms_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= load;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cms_mem.sv
module cms_mem #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bc_start,
  input  logic [DATA_W-1:0]        bc_data,
  input  logic [CODE_W-1:0]        bc_code,
  input  logic                     bc_wd,
  input  logic                     bc_wc,
  input  logic                     sw_en,
  input  logic [ADDR_W-1:0]        sw_addr,
  input  logic [DATA_W-1:0]        sw_data,
  input  logic [CODE_W-1:0]        sw_code,
  input  logic                     sw_wd,
  input  logic                     sw_wc,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [CODE_W+DATA_W-1:0] rd_entry
);
  localparam int IDX_W = ADDR_W + 1;

  logic [DATA_W-1:0] dmem [DEPTH];
  logic [CODE_W-1:0] cmem [DEPTH];
  logic              walking;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] w_data;
  logic [CODE_W-1:0] w_code;
  logic              w_d, w_c;
  logic [ADDR_W-1:0] w_addr;

  assign w_addr   = idx[ADDR_W-1:0];
  assign rd_entry = {cmem[rd_addr], dmem[rd_addr]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walking <= 1'b0;
      idx     <= '0;
      w_data  <= '0;
      w_code  <= '0;
      w_d     <= 1'b0;
      w_c     <= 1'b0;
    end else if (bc_start) begin
      walking <= 1'b1;
      idx     <= '0;
      w_data  <= bc_data;
      w_code  <= bc_code;
      w_d     <= bc_wd;
      w_c     <= bc_wc;
    end else if (walking) begin
      idx     <= idx + 1'b1;
      walking <= (idx != IDX_W'(DEPTH - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (walking) begin
      if (w_d) dmem[w_addr] <= w_data;
      if (w_c) cmem[w_addr] <= w_code;
    end else if (sw_en) begin
      if (sw_wd) dmem[sw_addr] <= sw_data;
      if (sw_wc) cmem[sw_addr] <= sw_code;
    end
  end
endmodule

// File: rtl/cms_seq.sv
module cms_seq
  import cms_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DATA_W  = 8,
  parameter int CODE_W  = 4,
  parameter int ADDR_W  = $clog2(DEPTH),
  parameter int FILL_T  = 512,
  parameter int INIT_T  = 5,
  parameter int NORM_T  = 19,
  parameter int SWEEP_T = 2070,
  parameter int TEST_T  = 4114
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_wr,
  input  logic [1:0]               mode_in,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic                     cmd_field,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [DATA_W-1:0]        cmd_data,
  output logic                     busy,
  output logic                     err,
  output logic                     ifc_en,
  output logic [1:0]               mode_out,
  output logic [CODE_W+DATA_W-1:0] host_rdata
);
  localparam int CNT_W = $clog2(FILL_T + INIT_T + NORM_T + SWEEP_T + TEST_T + 1);

  logic                     cmd_accept, op_done, bc_start;
  logic [CNT_W-1:0]         ticks_m1;
  logic [1:0]               op_q, mode_q;
  logic                     field_q;
  logic [ADDR_W-1:0]        addr_q, rd_addr;
  logic [DATA_W-1:0]        data_q;
  logic                     sw_en;
  logic [CODE_W+DATA_W-1:0] rd_entry;

  assign cmd_accept = cmd_valid && !busy;
  assign ticks_m1   = CNT_W'(op_ticks(mode_out, cmd_op, FILL_T, INIT_T, NORM_T, SWEEP_T, TEST_T) - 1);
  assign bc_start   = cmd_accept && ((mode_out == MODE_FILL) ||
                                     (mode_out == MODE_TEST && cmd_op == OP_WRITE));
  assign sw_en      = op_done && (op_q == OP_WRITE) &&
                      (mode_q == MODE_INIT || mode_q == MODE_NORM);
  assign rd_addr    = (mode_q == MODE_TEST) ? '0 : addr_q;
  assign ifc_en     = ifc_on(mode_out);

  cms_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wr_val(mode_in),
    .busy(busy), .done(op_done), .mode(mode_out)
  );

  cms_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cmd_accept), .load(ticks_m1),
    .busy(busy), .done(op_done)
  );

  cms_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .bc_start(bc_start), .bc_data(cmd_data),
    .bc_code((mode_out == MODE_FILL) ? '0 : cmd_data[CODE_W-1:0]),
    .bc_wd((mode_out == MODE_FILL) || !cmd_field),
    .bc_wc((mode_out == MODE_FILL) || cmd_field),
    .sw_en(sw_en), .sw_addr(addr_q), .sw_data(data_q), .sw_code(data_q[CODE_W-1:0]),
    .sw_wd(!field_q), .sw_wc(field_q),
    .rd_addr(rd_addr), .rd_entry(rd_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_READ;
      mode_q     <= MODE_FILL;
      field_q    <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      err        <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (cmd_accept) begin
        op_q    <= cmd_op;
        mode_q  <= mode_out;
        field_q <= cmd_field;
        addr_q  <= cmd_addr;
        data_q  <= cmd_data;
      end
      if (cmd_valid && busy) err <= 1'b1;
      if (op_done && op_is_read(op_q) && mode_q != MODE_FILL) host_rdata <= rd_entry;
    end
  end
endmodule

// File: rtl/cms_seq_chk.sv
module cms_seq_chk
  import cms_pkg::*;
#(
  parameter int FILL_T  = 512,
  parameter int INIT_T  = 5,
  parameter int NORM_T  = 19,
  parameter int SWEEP_T = 2070,
  parameter int TEST_T  = 4114
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       err,
  input logic       ifc_en,
  input logic [1:0] mode_out,
  input logic       cmd_accept,
  input logic       op_done
);
  int unsigned run_len, exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 0;
      exp_len <= 0;
    end else if (cmd_valid && !busy) begin
      run_len <= 0;
      exp_len <= op_ticks(mode_out, cmd_op, FILL_T, INIT_T, NORM_T, SWEEP_T, TEST_T);
    end else if (busy) begin
      run_len <= run_len + 1;
    end
  end

  a_r2_ifc_by_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ifc_en == (mode_out == MODE_NORM || mode_out == MODE_TEST));
  a_r9_busy_cmd_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> err);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mode_out) || !busy));
  a_r5_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == exp_len));
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !cmd_accept) |=> !busy);
endmodule

bind cms_seq cms_seq_chk #(
  .FILL_T(FILL_T), .INIT_T(INIT_T), .NORM_T(NORM_T), .SWEEP_T(SWEEP_T), .TEST_T(TEST_T)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy),
  .err(err), .ifc_en(ifc_en), .mode_out(mode_out), .cmd_accept(cmd_accept), .op_done(op_done)
);

// File: tb/tb_cms_seq.sv
module tb_cms_seq;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic mode_wr = 0, cmd_valid = 0, cmd_field = 0;
  logic [1:0] mode_in = 0, cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [7:0] cmd_data = 0;
  logic busy, err, ifc_en;
  logic [1:0] mode_out;
  logic [11:0] host_rdata;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cms_seq #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_field(cmd_field),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .err(err),
    .ifc_en(ifc_en), .mode_out(mode_out), .host_rdata(host_rdata)
  );

  // mode, op, field, addr, data, ticks, do-compare, expected {code,data}
  localparam int VW = 2 + 2 + 1 + 4 + 8 + 16 + 1 + 12;
  localparam logic [VW-1:0] VEC [10] = '{
    {2'b10, 2'b01, 1'b0, 4'd3,  8'h5A, 16'd5,  1'b0, 12'h000},
    {2'b10, 2'b01, 1'b1, 4'd3,  8'h09, 16'd5,  1'b0, 12'h000},
    {2'b10, 2'b00, 1'b0, 4'd3,  8'h00, 16'd5,  1'b1, 12'h95A},
    {2'b11, 2'b00, 1'b0, 4'd4,  8'h00, 16'd19, 1'b1, 12'h0FF},
    {2'b11, 2'b01, 1'b0, 4'd15, 8'h33, 16'd19, 1'b0, 12'h000},
    {2'b11, 2'b00, 1'b0, 4'd15, 8'h00, 16'd19, 1'b1, 12'h033},
    {2'b11, 2'b11, 1'b0, 4'd3,  8'h00, 16'd19, 1'b1, 12'h95A},
    {2'b10, 2'b01, 1'b1, 4'd0,  8'hFC, 16'd5,  1'b0, 12'h000},
    {2'b10, 2'b00, 1'b0, 4'd0,  8'h00, 16'd5,  1'b1, 12'hCFF},
    {2'b11, 2'b00, 1'b1, 4'd4,  8'h00, 16'd19, 1'b1, 12'h0FF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1; mode_in = m;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic fld, input logic [AW-1:0] a,
                       input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_field = fld; cmd_addr = a; cmd_data = d;
    @(negedge clk); cmd_valid = 0;
  endtask

  // counts busy ticks; the first busy negedge is already reached after issue
  task automatic run(input logic [1:0] op, input logic fld, input logic [AW-1:0] a,
                     input logic [7:0] d, output int len);
    issue(op, fld, a, d);
    len = 0;
    while (busy) begin len++; @(negedge clk); end
  endtask

  task automatic read_at(input logic [AW-1:0] a, output logic [11:0] r);
    int l;
    run(2'b00, 1'b0, a, 8'h00, l);
    r = host_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int len;
    logic [11:0] r;
    repeat (3) @(negedge clk);
    check("R1 mode", mode_out, 2'b00);
    check("R1 busy", busy, 0);
    check("R1 err", err, 0);
    check("R1 ifc_en", ifc_en, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 mode after release", mode_out, 2'b00);

    // R3: bulk fill with the unassigned value
    run(2'b01, 1'b1, 4'd7, 8'hFF, len);
    check("R3 fill ticks", len, 512);
    check("R2 ifc_en fill mode", ifc_en, 0);
    set_mode(2'b10);
    check("R2 mode init", mode_out, 2'b10);
    check("R2 ifc_en init", ifc_en, 0);
    read_at(4'd0, r);  check("R3 loc0", r, 12'h0FF);
    read_at(4'd15, r); check("R3 loc15", r, 12'h0FF);

    // R4 R5 R8 vector table
    foreach (VEC[i]) begin
      logic [VW-1:0] v;
      v = VEC[i];
      set_mode(v[45:44]);
      run(v[43:42], v[41], v[40:37], v[36:29], len);
      check(v[45:44] == 2'b10 ? "R4 ticks" : "R5 ticks", len, v[28:13]);
      if (v[12]) check("R8 read data", host_rdata, v[11:0]);
    end
    check("R2 ifc_en normal", ifc_en, 1);

    // R6 sweep in normal mode, memory unchanged
    run(2'b10, 1'b0, 4'd3, 8'h11, len);
    check("R6 sweep ticks", len, 2070);
    read_at(4'd3, r); check("R6 untouched", r, 12'h95A);

    // R9: command during busy ignored, err sticky
    issue(2'b01, 1'b0, 4'd2, 8'hEE);
    check("R9 err clear before", err, 0);
    issue(2'b01, 1'b0, 4'd2, 8'hEE);
    @(negedge clk);
    check("R9 err set", err, 1);
    // R10: mode write during busy deferred
    set_mode(2'b01);
    check("R10 mode held", mode_out, 2'b11);
    while (busy) @(negedge clk);
    check("R10 mode applied", mode_out, 2'b01);
    check("R2 ifc_en test", ifc_en, 1);
    check("R9 err sticky", err, 1);

    // R7 test mode broadcast write of data field, address ignored
    run(2'b01, 1'b0, 4'd5, 8'h77, len);
    check("R7 test ticks", len, 4114);
    run(2'b00, 1'b0, 4'd9, 8'h00, len);
    check("R7 test read ticks", len, 4114);
    check("R7 read loc0", host_rdata, 12'hC77);
    set_mode(2'b10);
    read_at(4'd2, r);  check("R9 ignored write", r, 12'h077);
    read_at(4'd15, r); check("R7 loc15", r, 12'h077);
    read_at(4'd3, r);  check("R7 code kept", r, 12'h977);

    // R3 second fill clears codes
    set_mode(2'b00);
    run(2'b00, 1'b0, 4'd0, 8'hA5, len);
    check("R3 refill ticks", len, 512);
    set_mode(2'b10);
    read_at(4'd3, r); check("R3 code cleared", r, 12'h0A5);
    read_at(4'd0, r); check("R3 loc0 refill", r, 12'h0A5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule